// File: doc/BRIEF.md
# Four-Mode Lamp Pattern Sequencer

This block drives a row of three lamps through one of four short repeating light patterns. A two-bit mode input selects the pattern, and the pattern advances once per clock. The lamp outputs are the state register itself, so the lamps change only on a clock edge and never glitch when the mode input changes. Every pattern begins at all-off, visits three lit states and returns to all-off.

The next-state logic follows a minimum-risk rule. A state that is not a step of the pattern the current mode selects is sent to all-off on the next clock, and so is the one encoding that no pattern uses. If the mode changes in the middle of a pattern, the sequencer either carries on, when the present state also belongs to the new pattern, or drops to all-off and starts the new pattern from there.

A slow clock and the lamp drivers are supplied by the surrounding logic.

Top module: `lamp_seq_top`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the lamps are all off (`lamps` = 000) after that edge, and they stay off for as long as `rst_n` stays low.
- R2: The lamps change only at a rising clock edge. A change of `mode` between edges leaves `lamps` unchanged until the next edge.
- R3: With `mode` = 0, the lamps step 000, 100, 010, 001 and back to 000, one step per clock (`lamps[2]` is the leftmost digit).
- R4: With `mode` = 1, the lamps step 000, 001, 010, 100 and back to 000.
- R5: With `mode` = 2, the lamps step 000, 100, 110, 111 and back to 000.
- R6: With `mode` = 3, the lamps step 000, 001, 011, 111 and back to 000.
- R7: A state that is not one of the four steps of the pattern selected by the present `mode` goes to 000 at the next clock. This covers 101 under every mode, single-lamp states 010 under modes 2 and 3, and two-lamp states under modes 0 and 1.
- R8: From 111 the lamps go to 000 at the next clock under every mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the pattern advances on each rising edge |
| rst_n | input | 1 | Synchronous reset, active low; forces all lamps off |
| mode | input | 2 | Pattern select, values 0 to 3 as listed in R3 to R6 |
| lamps | output | 3 | Lamp drive, one bit per lamp, equal to the state register |

## Verification
The hard cases are the states that only one pattern visits, seen under a mode that does not own them. From the ports these arise only by switching the mode mid-pattern. The stimulus therefore walks every mode to every depth of its pattern from reset, switches to each of the four modes, and checks the edge that follows. The unused code 101 cannot be reached through the ports at all. Its exit to all-off is covered by the next-state function being total and by an assertion beside the state register. Long runs of random mode changes with occasional resets then mix in-pattern continuation with recovery through all-off.

// File: rtl/lamp_seq_pkg.sv
// Package: shared widths, types and the pattern table for the lamp sequencer.
// Assumes every pattern has the same number of steps and that step 0 is all-off.
package lamp_seq_pkg;

    localparam int MODE_W    = 2;
    localparam int LAMP_W    = 3;
    localparam int NUM_MODES = 1 << MODE_W;
    localparam int STEPS     = 4;
    localparam int STEP_W    = $clog2(STEPS);

    typedef logic [MODE_W-1:0] mode_t;
    typedef logic [LAMP_W-1:0] lamp_t;

    localparam lamp_t LAMPS_OFF = '0;

    // Lamp word of pattern step idx in mode m; step 0 is always all-off.
    function automatic lamp_t pattern_step(input int m, input int idx);
        lamp_t r;
        r = LAMPS_OFF;
        case (m)
            0: case (idx)
                   1: r = 3'b100;
                   2: r = 3'b010;
                   3: r = 3'b001;
                   default: r = LAMPS_OFF;
               endcase
            1: case (idx)
                   1: r = 3'b001;
                   2: r = 3'b010;
                   3: r = 3'b100;
                   default: r = LAMPS_OFF;
               endcase
            2: case (idx)
                   1: r = 3'b100;
                   2: r = 3'b110;
                   3: r = 3'b111;
                   default: r = LAMPS_OFF;
               endcase
            3: case (idx)
                   1: r = 3'b001;
                   2: r = 3'b011;
                   3: r = 3'b111;
                   default: r = LAMPS_OFF;
               endcase
            default: r = LAMPS_OFF;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lamp_seq_match.sv
// Module: per-mode step matcher. Compares the present state against each step
// of one mode's pattern and returns the following step, or all-off when the
// state is not a step of this pattern (minimum-risk default).
// Assumes the steps of one pattern are distinct, so at most one compare hits.
module lamp_seq_match
    import lamp_seq_pkg::*;
#(
    parameter int MODE_ID = 0
) (
    input  lamp_t cur_state,
    output lamp_t succ_state,
    output logic  on_path
);

    localparam int LAST_STEP = STEPS - 1;

    logic  [STEPS-1:0] step_hit;
    lamp_t             step_succ [STEPS];

    for (genvar k = 0; k < STEPS; k++) begin : g_step
        localparam lamp_t HERE = pattern_step(MODE_ID, k);
        localparam lamp_t NEXT = pattern_step(MODE_ID, (k == LAST_STEP) ? 0 : k + 1);
        // Compare against one step and gate its successor.
        always_comb begin
            step_hit[k]  = (cur_state == HERE);
            step_succ[k] = step_hit[k] ? NEXT : LAMPS_OFF;
        end
    end

    // Merge successor candidates; an unmatched state yields all-off.
    always_comb begin
        succ_state = LAMPS_OFF;
        for (int k = 0; k < STEPS; k++) begin
            succ_state = succ_state | step_succ[k];
        end
        on_path = |step_hit;
    end

endmodule

// File: rtl/lamp_seq_next.sv
// Module: next-state logic. One matcher per mode, selected by the mode input.
// Assumes the mode input is stable around the clock edge (synchronous).
module lamp_seq_next
    import lamp_seq_pkg::*;
(
    input  mode_t mode_sel,
    input  lamp_t cur_state,
    output lamp_t next_state,
    output logic  in_pattern
);

    lamp_t       cand   [NUM_MODES];
    logic [NUM_MODES-1:0] on_path;

    for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
        lamp_seq_match #(.MODE_ID(m)) match_i (
            .cur_state (cur_state),
            .succ_state(cand[m]),
            .on_path   (on_path[m])
        );
    end

    // Pick the successor of the selected mode.
    always_comb begin
        next_state = cand[mode_sel];
        in_pattern = on_path[mode_sel];
    end

endmodule

// File: rtl/lamp_seq_state.sv
// Module: state register whose bits are the lamp drive (Moore outputs).
// Assumes synchronous active-low reset.
module lamp_seq_state
    import lamp_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  lamp_t d_state,
    output lamp_t q_state
);

    // Capture the next state or clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q_state <= LAMPS_OFF;
        else        q_state <= d_state;
    end

    // R7: the unused code always exits to all-off.
    a_r7_unused_exits: assert property (@(posedge clk) disable iff (!rst_n)
        (q_state == 3'b101) |=> (q_state == LAMPS_OFF));

    // R8: the full-on state always exits to all-off.
    a_r8_full_exits: assert property (@(posedge clk) disable iff (!rst_n)
        (q_state == 3'b111) |=> (q_state == LAMPS_OFF));

endmodule

// File: rtl/lamp_seq_top.sv
// Module: four-mode lamp pattern sequencer, Moore machine whose state is the
// lamp word. Off-pattern states fall back to all-off on the next clock.
// Assumes mode is synchronous to clk; lamp drivers sit outside.
module lamp_seq_top
    import lamp_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MODE_W-1:0] mode,
    output logic [LAMP_W-1:0] lamps
);

    lamp_t state_q;
    lamp_t state_d;
    logic  in_pattern;

    lamp_seq_next next_i (
        .mode_sel  (mode),
        .cur_state (state_q),
        .next_state(state_d),
        .in_pattern(in_pattern)
    );

    lamp_seq_state state_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_state(state_d),
        .q_state(state_q)
    );

    // Drive the lamps straight from the state bits.
    always_comb lamps = state_q;

    // R1: a reset edge leaves all lamps off.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (lamps == LAMPS_OFF));

    // R7: an off-pattern state for the present mode falls to all-off.
    a_r7_off_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        !in_pattern |=> (lamps == LAMPS_OFF));

    // R7: single-lamp modes never keep more than one lamp lit.
    a_r7_multi_in_single: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode[1] && ($countones(lamps) > 1)) |=> (lamps == LAMPS_OFF));

    // R3, R5: from all-off, even modes light the left lamp first.
    a_r3_left_first: assert property (@(posedge clk) disable iff (!rst_n)
        ((lamps == LAMPS_OFF) && !mode[0]) |=> (lamps == 3'b100));

    // R4, R6: from all-off, odd modes light the right lamp first.
    a_r4_right_first: assert property (@(posedge clk) disable iff (!rst_n)
        ((lamps == LAMPS_OFF) && mode[0]) |=> (lamps == 3'b001));

endmodule

// File: tb/lamp_seq_top_tb_top.sv
module lamp_seq_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] mode;
    logic [2:0] lamps;

    int n_cmp = 0;
    int n_bad = 0;
    logic [2:0] exp_l;

    always #4 clk = ~clk;

    lamp_seq_top dut_i (
        .clk  (clk),
        .rst_n(rst_n),
        .mode (mode),
        .lamps(lamps)
    );

    // Pattern steps taken from R3..R6.
    function automatic logic [2:0] cyc(input int m, input int k);
        logic [2:0] t [4][4];
        t[0] = '{3'b000, 3'b100, 3'b010, 3'b001};
        t[1] = '{3'b000, 3'b001, 3'b010, 3'b100};
        t[2] = '{3'b000, 3'b100, 3'b110, 3'b111};
        t[3] = '{3'b000, 3'b001, 3'b011, 3'b111};
        return t[m][k];
    endfunction

    function automatic logic in_cyc(input logic [2:0] s, input int m);
        for (int k = 0; k < 4; k++) if (cyc(m, k) == s) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [2:0] ref_next(input logic [2:0] s, input int m);
        for (int k = 0; k < 4; k++) if (cyc(m, k) == s) return cyc(m, (k + 1) % 4);
        return 3'b000;
    endfunction

    function automatic string tag_for(input logic [2:0] s, input int m);
        if (s == 3'b111) return "R8";
        if (!in_cyc(s, m)) return "R7";
        case (m)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s lamps=%b expected=%b", tag, act, exp);
        end
    endtask

    // Called at a negedge: apply mode, let one edge pass, compare.
    task automatic step(input int m);
        string tg;
        tg    = tag_for(exp_l, m);
        mode  = m[1:0];
        exp_l = ref_next(exp_l, m);
        @(negedge clk);
        chk(tg, lamps, exp_l);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        exp_l = 3'b000;
        chk("R1", lamps, exp_l);
        rst_n = 1'b1;
    endtask

    initial begin
        rst_n = 1'b0;
        mode  = 2'd0;
        exp_l = 3'b000;
        @(negedge clk);
        @(negedge clk);
        chk("R1", lamps, 3'b000);
        // R1: held reset with a running mode keeps lamps off
        mode = 2'd3;
        @(negedge clk);
        chk("R1", lamps, 3'b000);
        rst_n = 1'b1;

        // R3..R6: each mode for three full periods
        for (int m = 0; m < 4; m++) begin
            do_reset();
            for (int i = 0; i < 12; i++) step(m);
        end

        // R2: mode change between edges leaves lamps untouched
        do_reset();
        step(2);
        step(2);
        mode = 2'd1;
        #1;
        chk("R2", lamps, exp_l);
        mode = 2'd2;
        step(2);

        // R7, R8: every reachable state under every mode via mid-pattern switch
        for (int s = 0; s < 4; s++)
            for (int k = 0; k < 4; k++)
                for (int t = 0; t < 4; t++) begin
                    do_reset();
                    for (int i = 0; i < k; i++) step(s);
                    step(t);
                    step(t);
                end

        // Random mode changes with occasional reset
        void'($urandom(32'h1A3B5C7D));
        for (int i = 0; i < 4000; i++) begin
            if (($urandom % 64) == 0) do_reset();
            else step(int'($urandom % 4));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired lamps=%b expected=%b", lamps, exp_l);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule